// File: doc/BRIEF.md
# Control Flow Signature Watchdog

This block watches the instruction fetch stream of a processor from the side and confirms that each straight-line block of code ran as compiled. Every block starts with a header word. The header is coded as a no-operation, so the processor skips it. It holds a reference signature and a cycle budget for the block. Every fetch after the header is folded into a running signature by a linear feedback shift register. When the branch that closes the block is reported, the watchdog compares the running signature with the reference.

A mismatch means the fetch sequence was corrupted, for example by a wrong jump or a damaged bus word. A block that is not closed within its cycle budget is reported as a hang. Both faults set a sticky error that stays until software or a supervisor pulses the clear input. When execution lands in the middle of a block, the watchdog stays idle until it sees the next header.

Top module: `cfw_watchdog`

## Requirements
- R1: After reset, error_o, err_sig_o, err_timeout_o and in_block_o are all 0.
- R2: A header is a valid fetch whose bits [31:26] equal 6'h15 and whose signature field, bits [15:0], is nonzero. Its budget field is bits [25:16]. in_block_o is 1 from the clock edge that accepts the header. A word with that opcode and a zero signature field is not a header.
- R3: The running signature starts at 0 at each accepted header. The header word itself is not folded in. Every valid fetch after the header, up to and including the one that arrives with the branch strobe, updates the signature s to (s<<1) ^ (s[15] ? 16'h1021 : 0) ^ w[31:16] ^ w[15:0].
- R4: A branch strobe inside a block starts a check cycle. If the signatures match, the next edge returns the watchdog to waiting: in_block_o goes to 0 and error_o stays 0.
- R5: If the signatures differ, the edge that ends the check cycle sets error_o and err_sig_o, and err_timeout_o stays 0.
- R6: While the watchdog is waiting, it ignores non-header fetches and branch strobes. It stays out of a block and raises no error.
- R7: After a header with budget B, a strobe is accepted in any of the first B cycles. If no strobe arrives by cycle B, error_o and err_timeout_o are set at that cycle's edge. A budget of 0 acts as a budget of 1.
- R8: The error flags are sticky until clear_i. clear_i returns the watchdog to waiting with all flags at 0, and it takes priority over a header in the same cycle.
- R9: A header fetched during the check cycle of a matching block starts the next block at once.
- R10: A header-formatted word fetched inside a block is folded into the signature like any other word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | A fetch word is present this cycle |
| fetch_word_i | input | 32 | Fetched instruction word |
| branch_i | input | 1 | The block-ending branch is fetched this cycle |
| clear_i | input | 1 | Clears the sticky error and returns to waiting |
| in_block_o | output | 1 | Watchdog is inside a block or its check cycle |
| error_o | output | 1 | Sticky fault flag |
| err_sig_o | output | 1 | Fault cause: signature mismatch |
| err_timeout_o | output | 1 | Fault cause: block budget exceeded |

## Verification
The hardest situation to reach is the meeting of two block boundaries. This covers a strobe in exactly the last budget cycle, and a new header arriving in the single check cycle of the previous block. The stimulus counts cycles from each header to reach both. It places a header in the check cycle and then corrupts the following block, which proves that block is really tracked. Random blocks with fetch gaps, stray header-formatted words and corrupted references then run against a bench model of the signature.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_CHECK = 2'd2,
    ST_FAULT = 2'd3
  } cfw_state_e;
endpackage

// File: rtl/cfw_header_decode.sv
module cfw_header_decode #(
  parameter int          WORD_W = 32,
  parameter int          OP_W   = 6,
  parameter int          SIG_W  = 16,
  parameter int          TMO_W  = 10,
  parameter logic [5:0]  NOP_OP = 6'h15
) (
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              is_hdr_o,
  output logic [SIG_W-1:0]  ref_sig_o,
  output logic [TMO_W-1:0]  budget_o
);
  localparam int USED_W = OP_W + TMO_W + SIG_W;

  logic [OP_W-1:0] opcode;

  assign opcode    = word_i[WORD_W-1 -: OP_W];
  assign ref_sig_o = word_i[SIG_W-1:0];
  assign budget_o  = word_i[SIG_W +: TMO_W];
  assign is_hdr_o  = valid_i && (opcode == NOP_OP[OP_W-1:0]) && (ref_sig_o != '0);

  initial begin
    a_r2_fields_fit: assert (USED_W <= WORD_W)
      else $error("header fields exceed word width");
  end
endmodule

// File: rtl/cfw_sig_lfsr.sv
module cfw_sig_lfsr #(
  parameter int               WORD_W = 32,
  parameter int               SIG_W  = 16,
  parameter logic [SIG_W-1:0] POLY   = 16'h1021
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_i,
  input  logic              step_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [SIG_W-1:0]  sig_o
);
  localparam int SLICES = (WORD_W + SIG_W - 1) / SIG_W;
  localparam int PAD_W  = SLICES * SIG_W;

  logic [PAD_W-1:0] padded;
  logic [SIG_W-1:0] folded;
  logic [SIG_W-1:0] sig_q;
  logic [SIG_W-1:0] sig_next;

  assign padded = PAD_W'(word_i);

  always_comb begin
    folded = '0;
    for (int i = 0; i < SLICES; i++) begin
      folded = folded ^ padded[i*SIG_W +: SIG_W];
    end
  end

  assign sig_next = {sig_q[SIG_W-2:0], 1'b0}
                  ^ (sig_q[SIG_W-1] ? POLY : '0)
                  ^ folded;

  always_ff @(posedge clk) begin
    if (rst || seed_i) begin
      sig_q <= '0;
    end else if (step_i) begin
      sig_q <= sig_next;
    end
  end

  assign sig_o = sig_q;

  a_r3_hold_without_step: assert property (@(posedge clk) disable iff (rst)
    (!seed_i && !step_i) |=> $stable(sig_q));
endmodule

// File: rtl/cfw_block_timer.sv
module cfw_block_timer #(
  parameter int TMO_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] budget_i,
  output logic             expired_o
);
  localparam int TW1 = TMO_W + 1;

  logic [TMO_W-1:0] cnt_q;
  logic [TW1-1:0]   elapsed;

  assign elapsed   = {1'b0, cnt_q} + TW1'(1);
  assign expired_o = elapsed >= {1'b0, budget_i};

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != '1)) begin
      cnt_q <= cnt_q + TMO_W'(1);
    end
  end

  a_r7_within_budget: assert property (@(posedge clk) disable iff (rst)
    (run_i && !restart_i) |-> ((cnt_q < budget_i) || (cnt_q == '0)));
endmodule

// File: rtl/cfw_watchdog.sv
module cfw_watchdog #(
  parameter int               WORD_W = 32,
  parameter int               OP_W   = 6,
  parameter int               SIG_W  = 16,
  parameter int               TMO_W  = 10,
  parameter logic [5:0]       NOP_OP = 6'h15,
  parameter logic [SIG_W-1:0] POLY   = 16'h1021
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid_i,
  input  logic [WORD_W-1:0] fetch_word_i,
  input  logic              branch_i,
  input  logic              clear_i,
  output logic              in_block_o,
  output logic              error_o,
  output logic              err_sig_o,
  output logic              err_timeout_o
);
  import cfw_pkg::*;

  cfw_state_e       state_q, state_d;
  logic             hdr_seen;
  logic [SIG_W-1:0] hdr_sig;
  logic [TMO_W-1:0] hdr_budget;
  logic [SIG_W-1:0] ref_q;
  logic [TMO_W-1:0] budget_q;
  logic [SIG_W-1:0] run_sig;
  logic             expired;
  logic             load_blk;
  logic             set_sig, set_tmo;
  logic             sig_match;
  logic             in_block_q, err_q, err_sig_q, err_tmo_q;

  cfw_header_decode #(
    .WORD_W(WORD_W), .OP_W(OP_W), .SIG_W(SIG_W), .TMO_W(TMO_W), .NOP_OP(NOP_OP)
  ) hdr_dec_i (
    .valid_i  (fetch_valid_i),
    .word_i   (fetch_word_i),
    .is_hdr_o (hdr_seen),
    .ref_sig_o(hdr_sig),
    .budget_o (hdr_budget)
  );

  cfw_sig_lfsr #(
    .WORD_W(WORD_W), .SIG_W(SIG_W), .POLY(POLY)
  ) lfsr_i (
    .clk   (clk),
    .rst   (rst),
    .seed_i(load_blk),
    .step_i(state_q == ST_RUN && fetch_valid_i && !clear_i),
    .word_i(fetch_word_i),
    .sig_o (run_sig)
  );

  cfw_block_timer #(
    .TMO_W(TMO_W)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .restart_i(load_blk),
    .run_i    (state_q == ST_RUN && !clear_i),
    .budget_i (budget_q),
    .expired_o(expired)
  );

  assign sig_match = (run_sig == ref_q);

  always_comb begin
    state_d  = state_q;
    load_blk = 1'b0;
    set_sig  = 1'b0;
    set_tmo  = 1'b0;
    if (clear_i) begin
      state_d = ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (hdr_seen) begin
            load_blk = 1'b1;
            state_d  = ST_RUN;
          end
        end
        ST_RUN: begin
          if (branch_i) begin
            state_d = ST_CHECK;
          end else if (expired) begin
            set_tmo = 1'b1;
            state_d = ST_FAULT;
          end
        end
        ST_CHECK: begin
          if (!sig_match) begin
            set_sig = 1'b1;
            state_d = ST_FAULT;
          end else if (hdr_seen) begin
            load_blk = 1'b1;
            state_d  = ST_RUN;
          end else begin
            state_d = ST_WAIT;
          end
        end
        default: state_d = ST_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_WAIT;
      ref_q      <= '0;
      budget_q   <= '0;
      in_block_q <= 1'b0;
      err_q      <= 1'b0;
      err_sig_q  <= 1'b0;
      err_tmo_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      in_block_q <= (state_d == ST_RUN) || (state_d == ST_CHECK);
      if (load_blk) begin
        ref_q    <= hdr_sig;
        budget_q <= hdr_budget;
      end
      if (clear_i) begin
        err_q     <= 1'b0;
        err_sig_q <= 1'b0;
        err_tmo_q <= 1'b0;
      end else begin
        if (set_sig || set_tmo) err_q <= 1'b1;
        if (set_sig)            err_sig_q <= 1'b1;
        if (set_tmo)            err_tmo_q <= 1'b1;
      end
    end
  end

  assign in_block_o    = in_block_q;
  assign error_o       = err_q;
  assign err_sig_o     = err_sig_q;
  assign err_timeout_o = err_tmo_q;

  a_r8_sticky_error: assert property (@(posedge clk) disable iff (rst)
    (error_o && !clear_i) |=> error_o);

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (!error_o && !in_block_o));

  a_r5_single_cause: assert property (@(posedge clk) disable iff (rst)
    error_o |-> $onehot({err_sig_o, err_timeout_o}));

  a_r6_wait_ignores: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !hdr_seen) |=> (state_q == ST_WAIT && !in_block_o));

  a_r7_timeout_flag: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && expired && !branch_i && !clear_i) |=> err_timeout_o);

  a_r4_check_once: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHECK) |=> (state_q != ST_CHECK));
endmodule

// File: tb/cfw_watchdog_tb_top.sv
module cfw_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        fv, bs, cl;
  logic [31:0] fw;
  logic        in_blk, err, esig, etmo;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cfw_watchdog dut_i (
    .clk(clk), .rst(rst), .fetch_valid_i(fv), .fetch_word_i(fw),
    .branch_i(bs), .clear_i(cl), .in_block_o(in_blk), .error_o(err),
    .err_sig_o(esig), .err_timeout_o(etmo)
  );

  function automatic logic [15:0] sig_step(input logic [15:0] s, input logic [31:0] w);
    return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0000) ^ w[31:16] ^ w[15:0];
  endfunction

  function automatic logic [31:0] mk_hdr(input logic [15:0] s, input logic [9:0] b);
    return {6'h15, b, s};
  endfunction

  task automatic cyc(input logic v, input logic [31:0] w, input logic s, input logic c);
    @(negedge clk);
    fv = v; fw = w; bs = s; cl = c;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic flags(input string req, input logic eb, input logic ee, input logic es, input logic et);
    check(req, {28'd0, in_blk, err, esig, etmo}, {28'd0, eb, ee, es, et});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, r;
    logic [31:0] w0, w1, w2;
    logic [31:0] bw [16];
    logic        bv [16];
    int          n;
    bit          bad;
    void'($urandom(32'h5eed_c0de));
    rst = 1'b1; fv = 0; fw = 0; bs = 0; cl = 0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    flags("R1 reset", 0, 0, 0, 0);

    // R6: noise and strobes while waiting; R2: zero signature is not a header
    cyc(1, 32'h1234_5678, 1, 0);
    cyc(1, mk_hdr(16'h0000, 10'd5), 0, 0);
    cyc(0, 32'h0, 1, 0);
    flags("R6 ignored while waiting", 0, 0, 0, 0);
    check("R2 zero-signature word not a header", {31'd0, in_blk}, 0);

    // R2/R3/R4: good block
    w0 = 32'hDEAD_BEEF; w1 = 32'h0000_0001; w2 = 32'h4000_8000;
    s = sig_step(sig_step(sig_step(16'h0, w0), w1), w2);
    cyc(1, mk_hdr(s, 10'd20), 0, 0);
    flags("R2 header enters block", 1, 0, 0, 0);
    cyc(1, w0, 0, 0); cyc(0, 32'hFFFF_FFFF, 0, 0); cyc(1, w1, 0, 0);
    cyc(1, w2, 1, 0);
    flags("R4 check cycle in block", 1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    flags("R3 R4 match returns to wait", 0, 0, 0, 0);

    // R5: corrupted reference, then R8 stickiness and clear priority
    cyc(1, mk_hdr(s ^ 16'h0040, 10'd20), 0, 0);
    cyc(1, w0, 0, 0); cyc(1, w1, 0, 0); cyc(1, w2, 1, 0);
    cyc(0, 0, 0, 0);
    flags("R5 mismatch sets signature error", 0, 1, 1, 0);
    cyc(1, mk_hdr(16'h0001, 10'd3), 1, 0);
    cyc(0, 0, 0, 0);
    flags("R8 error sticky", 0, 1, 1, 0);
    cyc(1, mk_hdr(16'h0001, 10'd3), 0, 1);
    flags("R8 clear beats header", 0, 0, 0, 0);

    // R7: budget 5, no strobe
    cyc(1, mk_hdr(16'h00AA, 10'd5), 0, 0);
    repeat (4) cyc(1, 32'h1111_1111, 0, 0);
    flags("R7 still within budget", 1, 0, 0, 0);
    cyc(1, 32'h1111_1111, 0, 0);
    flags("R7 timeout at budget", 0, 1, 0, 1);
    cyc(0, 0, 0, 1);

    // R7: strobe exactly in the last budget cycle
    s = sig_step(16'h0, 32'h0000_00C3);
    cyc(1, mk_hdr(s, 10'd4), 0, 0);
    repeat (3) cyc(0, 0, 0, 0);
    cyc(1, 32'h0000_00C3, 1, 0);
    cyc(0, 0, 0, 0);
    flags("R7 strobe in last budget cycle accepted", 0, 0, 0, 0);

    // R7: budget 0 acts as 1
    cyc(1, mk_hdr(16'h0101, 10'd0), 0, 0);
    cyc(0, 0, 0, 0);
    flags("R7 zero budget times out after one cycle", 0, 1, 0, 1);
    cyc(0, 0, 0, 1);

    // R9: back-to-back header in the check cycle; R10: header word inside block
    s = sig_step(16'h0, w0);
    r = sig_step(sig_step(16'h0, mk_hdr(16'h7777, 10'd9)), w1);
    cyc(1, mk_hdr(s, 10'd8), 0, 0);
    cyc(1, w0, 1, 0);
    cyc(1, mk_hdr(r, 10'd8), 0, 0);
    flags("R9 next block starts in check cycle", 1, 0, 0, 0);
    cyc(1, mk_hdr(16'h7777, 10'd9), 0, 0);
    cyc(1, w1, 1, 0);
    cyc(0, 0, 0, 0);
    flags("R10 header word folded into signature", 0, 0, 0, 0);
    cyc(1, mk_hdr(s, 10'd8), 0, 0);
    cyc(1, w0, 1, 0);
    cyc(1, mk_hdr(r ^ 16'h8000, 10'd8), 0, 0);
    cyc(1, mk_hdr(16'h7777, 10'd9), 0, 0);
    cyc(1, w1, 1, 0);
    cyc(0, 0, 0, 0);
    flags("R9 chained block is checked", 0, 1, 1, 0);
    cyc(0, 0, 0, 1);

    // Random blocks
    for (int k = 0; k < 300; k++) begin
      n = 1 + int'($urandom % 10);
      for (int i = 0; i < n; i++) begin
        bw[i] = $urandom;
        bv[i] = ($urandom % 4) != 0;
      end
      bv[n-1] = 1'b1;
      do begin
        s = 16'h0;
        for (int i = 0; i < n; i++) if (bv[i]) s = sig_step(s, bw[i]);
        if (s == 16'h0) bw[n-1] = bw[n-1] ^ 32'h1;
      end while (s == 16'h0);
      bad = ($urandom % 3) == 0;
      r = bad ? (s ^ (16'h1 << ($urandom % 16))) : s;
      if (r == 16'h0) r = 16'h8001;
      repeat ($urandom % 3) cyc(1, {6'h00, 26'($urandom)}, $urandom % 2, 0);
      cyc(1, mk_hdr(r, 10'(n + ($urandom % 4))), 0, 0);
      for (int i = 0; i < n; i++) cyc(bv[i], bw[i], i == n - 1, 0);
      check("R3 random block in check cycle", {31'd0, in_blk}, 1);
      cyc(0, 0, 0, 0);
      flags(bad ? "R5 random mismatch" : "R4 random match", 0, bad, bad, 0);
      if (bad) cyc(0, 0, 0, 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule